// File: doc/BRIEF.md
# Token-Ring Subtractive GCD Engine

This block computes the greatest common divisor of unsigned operand pairs by repeated subtraction. The work is done in a closed ring of elastic pipeline stages that pass valid/ready handshakes. A pair enters through a merge at the head of the ring. At the tail, the pair is tested for equality. An equal pair leaves on the result channel. An unequal pair has its larger member reduced by the smaller one and goes back to the merge for another lap.

Each lap forms both differences, first minus second and second minus first, in parallel. A less-than result then chooses which operand is replaced. Several pairs circulate at once and do not depend on each other. Every pair carries a small tag, so a caller can match results that come back in an order other than the order of entry. The merge admits a new pair only when the ring has a free token slot and no recirculating pair is waiting for the head. Recirculating pairs therefore always get back in, and the ring never locks up.

Top module: `gcd_ring`

## Requirements
- R1: After reset the ring is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: Each result on `out_gcd` equals the greatest common divisor of the nonzero operands `in_a` and `in_b` that were accepted with the same tag. Every accepted pair produces exactly one result.
- R3: The 3-bit `in_tag` accepted with a pair comes back unchanged on `out_tag` with that pair's result. No tag is returned unless a pair with that tag is outstanding.
- R4: At most 4 pairs are inside the engine at once. `in_ready` is 0 whenever 4 pairs have been accepted and not yet delivered.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with `out_gcd` and `out_tag` unchanged.
- R6: Results may leave out of order. A pair that needs few subtractions and is accepted after a pair that needs many leaves first.
- R7: A pair that is alone in the engine, with `out_ready` held at 1, first shows `out_valid` 5*(k+1) cycles after the cycle in which it was accepted. Here k is the number of subtraction steps needed to make the two values equal. An equal pair (k=0) therefore appears after 5 cycles, with its value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The engine takes the offered pair this cycle |
| in_a | input | 16 | First operand, nonzero |
| in_b | input | 16 | Second operand, nonzero |
| in_tag | input | 3 | Caller's identifier for the pair |
| out_valid | output | 1 | A finished result is offered |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_gcd | output | 16 | Greatest common divisor |
| out_tag | output | 3 | Identifier of the finished pair |

## Verification
The hardest situation to reach is a full ring whose finished pairs are stuck at the tail, while a fifth pair waits at the input. That case shows that admission stops and that the blocked result holds still. The stimulus reaches it by holding the result channel closed and feeding four pairs that finish within a few laps. A fifth pair is then offered, and only later is the result channel opened. A separate phase checks overtaking by putting a pair that needs about two hundred laps ahead of an equal pair. A long randomised phase with random result backpressure then mixes pairs that are in every stage of the ring.

// File: rtl/gcd_ring_pkg.sv
package gcd_ring_pkg;
    parameter int unsigned OP_W  = 16;
    parameter int unsigned TAG_W = 3;

    typedef struct packed {
        logic [OP_W-1:0]  a;
        logic [OP_W-1:0]  b;
        logic [TAG_W-1:0] tag;
    } tok_t;

    typedef struct packed {
        logic valid;
        tok_t tok;
    } slot_t;
endpackage

// File: rtl/gcd_ring_stage.sv
module gcd_ring_stage
    import gcd_ring_pkg::*;
#(
    parameter bit HALF = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  tok_t up_tok,
    output logic up_ready,
    output logic dn_valid,
    output tok_t dn_tok,
    input  logic dn_ready
);
    slot_t s_d, s_q;

    generate
        if (HALF) begin : g_half
            assign up_ready = !s_q.valid;
        end else begin : g_full
            assign up_ready = !s_q.valid || dn_ready;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (s_q.valid && dn_ready) begin
            s_d.valid = 1'b0;
        end
        if (up_valid && up_ready) begin
            s_d.valid = 1'b1;
            s_d.tok   = up_tok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dn_valid = s_q.valid;
    assign dn_tok   = s_q.tok;
endmodule

// File: rtl/gcd_ring_step.sv
module gcd_ring_step
    import gcd_ring_pkg::*;
(
    input  tok_t cur,
    output logic done,
    output tok_t nxt
);
    logic [OP_W-1:0] diff_ab;
    logic [OP_W-1:0] diff_ba;
    logic            a_lt_b;

    always_comb begin
        diff_ab = cur.a - cur.b;
        diff_ba = cur.b - cur.a;
        a_lt_b  = cur.a < cur.b;
        done    = cur.a == cur.b;
        nxt.tag = cur.tag;
        nxt.a   = a_lt_b ? cur.a : diff_ab;
        nxt.b   = a_lt_b ? diff_ba : cur.b;
    end
endmodule

// File: rtl/gcd_ring.sv
module gcd_ring
    import gcd_ring_pkg::*;
#(
    parameter int unsigned STAGES = 5,
    parameter int unsigned CAP    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OP_W-1:0]  out_gcd,
    output logic [TAG_W-1:0] out_tag
);
    localparam int unsigned CNT_W = $clog2(CAP + 1);
    localparam int unsigned LAST  = STAGES - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    logic        up_v [STAGES];
    logic        up_r [STAGES];
    logic        dn_v [STAGES];
    logic        dn_r [STAGES];
    tok_t        up_t [STAGES];
    tok_t        dn_t [STAGES];
    logic [STAGES-1:0] occ;

    ctl_t ctl_d, ctl_q;
    logic head_done;
    tok_t head_nxt;
    logic loop_v;
    logic room;
    logic in_fire;
    logic out_fire;
    tok_t ext_tok;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            gcd_ring_stage #(.HALF(i == 0)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .up_valid (up_v[i]),
                .up_tok   (up_t[i]),
                .up_ready (up_r[i]),
                .dn_valid (dn_v[i]),
                .dn_tok   (dn_t[i]),
                .dn_ready (dn_r[i])
            );
            assign occ[i] = dn_v[i];
            if (i > 0) begin : g_link
                assign up_v[i]   = dn_v[i-1];
                assign up_t[i]   = dn_t[i-1];
                assign dn_r[i-1] = up_r[i];
            end
        end
    endgenerate

    gcd_ring_step u_step (
        .cur  (dn_t[LAST]),
        .done (head_done),
        .nxt  (head_nxt)
    );

    always_comb begin
        ext_tok.a   = in_a;
        ext_tok.b   = in_b;
        ext_tok.tag = in_tag;
    end

    assign loop_v     = dn_v[LAST] && !head_done;
    assign out_valid  = dn_v[LAST] && head_done;
    assign out_gcd    = dn_t[LAST].a;
    assign out_tag    = dn_t[LAST].tag;
    assign dn_r[LAST] = head_done ? out_ready : up_r[0];

    assign room     = ctl_q.cnt < CNT_W'(CAP);
    assign in_ready = room && !loop_v && up_r[0];
    assign up_v[0]  = loop_v || (in_valid && room);
    assign up_t[0]  = loop_v ? head_nxt : ext_tok;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cnt = ctl_q.cnt + CNT_W'(in_fire) - CNT_W'(out_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/gcd_ring_chk.sv
module gcd_ring_chk #(
    parameter int unsigned STAGES = 5,
    parameter int unsigned CAP    = 4,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned OP_W   = 16,
    parameter int unsigned TAG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OP_W-1:0]   out_gcd,
    input logic [TAG_W-1:0]  out_tag,
    input logic [STAGES-1:0] occ,
    input logic [CNT_W-1:0]  cnt
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_gcd) && $stable(out_tag)); // R5

    AST_TOKEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == int'(cnt)); // R4

    AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) >= CAP |-> !in_ready); // R4

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !(out_valid && out_ready) |=> int'(cnt) == int'($past(cnt)) + 1); // R4

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(in_valid && in_ready) |=> int'(cnt) + 1 == int'($past(cnt))); // R4
endmodule

bind gcd_ring gcd_ring_chk #(
    .STAGES (STAGES),
    .CAP    (CAP),
    .CNT_W  (CNT_W),
    .OP_W   (gcd_ring_pkg::OP_W),
    .TAG_W  (gcd_ring_pkg::TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_gcd   (out_gcd),
    .out_tag   (out_tag),
    .occ       (occ),
    .cnt       (ctl_q.cnt)
);

// File: tb/gcd_ring_tb.sv
module gcd_ring_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic [2:0]  in_tag = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_gcd;
    logic [2:0]  out_tag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int outstanding = 0;
    bit lat_en = 1'b0;
    bit rand_bp = 1'b0;
    bit exp_busy [8];
    int exp_val  [8];
    int exp_lat  [8];
    int acc_cyc  [8];
    int order_q [$];
    bit prev_ov = 1'b0;
    bit prev_or = 1'b0;
    int prev_g = 0;
    int prev_t = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcd_ring u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_tag    (in_tag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_gcd   (out_gcd),
        .out_tag   (out_tag)
    );

    function automatic int ref_gcd(int a, int b);
        while (a != b) begin
            if (a > b) a = a - b;
            else       b = b - a;
        end
        return a;
    endfunction

    function automatic int ref_steps(int a, int b);
        int n = 0;
        while (a != b) begin
            if (a > b) a = a - b;
            else       b = b - a;
            n++;
        end
        return n;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Per-clock reference model, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_ov && !prev_or) begin
                chk(out_valid && int'(out_gcd) == prev_g && int'(out_tag) == prev_t,
                    "R5 held result", int'(out_gcd), prev_g);
            end
            if (outstanding >= 4) begin
                chk(!in_ready, "R4 admission closed at capacity", int'(in_ready), 0);
            end
            if (in_valid && in_ready) begin
                chk(!exp_busy[in_tag], "R3 tag reused while outstanding", 1, 0);
                exp_busy[in_tag] = 1'b1;
                acc_cyc[in_tag]  = cyc;
                outstanding++;
            end
            if (out_valid && out_ready) begin
                chk(exp_busy[out_tag], "R3 returned tag outstanding", int'(exp_busy[out_tag]), 1);
                chk(int'(out_gcd) == exp_val[out_tag], "R2 gcd value", int'(out_gcd), exp_val[out_tag]);
                if (lat_en) begin
                    chk(cyc - acc_cyc[out_tag] == exp_lat[out_tag], "R7 latency",
                        cyc - acc_cyc[out_tag], exp_lat[out_tag]);
                end
                exp_busy[out_tag] = 1'b0;
                outstanding--;
                order_q.push_back(int'(out_tag));
            end
            prev_ov = out_valid;
            prev_or = out_ready;
            prev_g  = int'(out_gcd);
            prev_t  = int'(out_tag);
            if (cyc > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
                finish_run();
            end
        end
    end

    always @(posedge clk) begin
        if (rand_bp) begin
            #1;
            out_ready = ($urandom_range(0, 3) != 0);
        end
    end

    task automatic send(int a, int b, int tag);
        while (exp_busy[tag]) @(negedge clk);
        exp_val[tag] = ref_gcd(a, b);
        exp_lat[tag] = 5 * (ref_steps(a, b) + 1);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_a     = 16'(a);
        in_b     = 16'(b);
        in_tag   = 3'(tag);
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (outstanding != 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_busy[i] = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        // R7: lone pairs, latency 5*(k+1)
        lat_en = 1'b1;
        send(7, 7, 0);     drain();
        send(12, 8, 1);    drain();
        send(9, 6, 2);     drain();
        send(5, 35, 3);    drain();
        send(40000, 40000, 4); drain();
        lat_en = 1'b0;

        // R6: short pair overtakes long pair
        order_q.delete();
        send(200, 1, 4);
        send(6, 6, 5);
        drain();
        chk(order_q.size() == 2 && order_q[0] == 5, "R6 out-of-order exit",
            order_q.size() > 0 ? order_q[0] : -1, 5);

        // R4/R5: full ring, result channel closed
        @(posedge clk); #1; out_ready = 1'b0;
        send(10, 4, 0);
        send(3, 9, 1);
        send(8, 8, 2);
        send(21, 14, 3);
        fork
            send(15, 25, 4);
            begin
                repeat (60) @(negedge clk);
                chk(!in_ready, "R4 fifth pair blocked", int'(in_ready), 0);
                chk(outstanding == 4, "R4 outstanding count", outstanding, 4);
                chk(out_valid, "R5 result waiting", int'(out_valid), 1);
                @(posedge clk); #1; out_ready = 1'b1;
            end
        join
        drain();

        // R2/R3: random pairs with random backpressure
        rand_bp = 1'b1;
        for (int i = 0; i < 40; i++) begin
            send($urandom_range(1, 255), $urandom_range(1, 255), i % 8);
        end
        drain();
        rand_bp = 1'b0;
        @(posedge clk); #1; out_ready = 1'b1;
        @(negedge clk);
        chk(outstanding == 0, "R2 every pair delivered", outstanding, 0);
        chk(!out_valid, "R2 no extra result", int'(out_valid), 0);
        finish_run();
    end
endmodule